// File: doc/BRIEF.md
# Microprogram Sequencer with Condition Select

This block forms the address of the next microinstruction on every microcycle. The address sits in a register and drives the 9-bit address port of the microcode store. The microword read from that address returns to the block as a 4-bit control field, a 3-bit condition select, a branch target and, for opcode decode, a dispatch value. The control field picks one of four next-address sources: the current address plus one, the top of a small return stack, the branch target, or the dispatch value.

Any non-sequential choice can be made conditional. A built-in eight-way condition multiplexer picks one test bit from the zero, carry and negative flags, their inverses, an external condition input, or a constant. When the test fails, the sequencer continues with the current address plus one. A call pushes the return address, which is the current address plus one, onto a four-entry stack. A return pops the stack and wraps around on both overflow and underflow.

A wait input freezes the sequencer for slow memory cycles. A synchronous reset restarts it at address zero with an empty, cleared stack.

Top module: `mseq_core`

## Requirements
- R1: With source select `ctl_word[1:0]` = 00, or when the selected source is not taken, the next address is the current address plus one, wrapping from 511 to 0.
- R2: Source select 01, when taken, loads the stack top into the address and pops one entry.
- R3: Source select 10, when taken, loads `branch_tgt` into the address.
- R4: Source select 11, when taken, loads `dispatch_in` into the address.
- R5: The condition select `cond_sel` chooses the test bit as follows: 0 = constant true, 1 = zero flag, 2 = not zero, 3 = carry, 4 = not carry, 5 = negative, 6 = `ext_cond`, 7 = constant false.
- R6: When `ctl_word[2]` (conditional enable) is 1 and the selected test bit is 0, the source is not taken, and the stack neither pushes nor pops. When `ctl_word[2]` is 0, the source is always taken.
- R7: When `ctl_word[3]` (call) is 1 with a taken branch or dispatch, the current address plus one is pushed. The stack holds 4 entries and its pointer wraps, so a fifth push overwrites the oldest entry and a pop on an empty stack reads the last slot.
- R8: While `stall` is 1, the address and the stack hold their values.
- R9: A synchronous `rst` sets the address to 0, clears the stack pointer and zeroes every stack entry. Reset takes priority over `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microcycle clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_word | input | 4 | Control field: [1:0] source, [2] conditional enable, [3] call |
| cond_sel | input | 3 | Condition multiplexer select |
| flag_z | input | 1 | Zero status flag |
| flag_c | input | 1 | Carry status flag |
| flag_n | input | 1 | Negative status flag |
| ext_cond | input | 1 | External condition bit |
| branch_tgt | input | 9 | Branch target address from the microword |
| dispatch_in | input | 9 | Opcode dispatch address |
| stall | input | 1 | Wait: hold address and stack |
| uaddr | output | 9 | Current microcode address |

## Verification
The state that is hardest to reach from the ports is a stack that has wrapped. Getting there takes five taken calls in a row, with no pop in between. Each pop afterwards then has to be checked against the entry that the fifth call overwrote.

The stimulus builds this case on purpose. It makes five unconditional calls to chosen branch targets and then issues six returns, which runs the pointer past empty. It also places stalls between calls and returns to show that a frozen cycle leaves the pointer alone. A sweep of every condition select against all sixteen flag patterns separates taken and fallback cycles. A long randomized run mixes stalls and mid-run resets into arbitrary control words, and a behavioural model follows every cycle.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    // Next-address source, encoded in the low two bits of the control field
    typedef enum logic [1:0] {
        SRC_INC      = 2'b00,
        SRC_STACK    = 2'b01,
        SRC_BRANCH   = 2'b10,
        SRC_DISPATCH = 2'b11
    } src_e;

    // Control field of the microword
    typedef struct packed {
        logic push;
        logic cond_en;
        src_e src;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Condition multiplexer codes
    typedef enum logic [2:0] {
        CS_ONE     = 3'd0,
        CS_ZF      = 3'd1,
        CS_NZF     = 3'd2,
        CS_CF      = 3'd3,
        CS_NCF     = 3'd4,
        CS_NF      = 3'd5,
        CS_EXT     = 3'd6,
        CS_NEVER   = 3'd7
    } csel_e;

endpackage

// File: rtl/mseq_cond_mux.sv
module mseq_cond_mux
    import mseq_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             z,
    input  logic             c,
    input  logic             n,
    input  logic             ext,
    output logic             hit
);

    localparam int N_IN = 1 << SEL_W;

    logic [N_IN-1:0] cand;

    // Codes beyond the eight defined ones read as false
    always_comb begin
        cand                 = '0;
        cand[int'(CS_ONE)]   = 1'b1;
        cand[int'(CS_ZF)]    = z;
        cand[int'(CS_NZF)]   = ~z;
        cand[int'(CS_CF)]    = c;
        cand[int'(CS_NCF)]   = ~c;
        cand[int'(CS_NF)]    = n;
        cand[int'(CS_EXT)]   = ext;
        cand[int'(CS_NEVER)] = 1'b0;
    end

    assign hit = cand[sel];

endmodule

// File: rtl/mseq_next_sel.sv
module mseq_next_sel
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] cur,
    input  ctl_t              ctl,
    input  logic              hit,
    input  logic [ADDR_W-1:0] stk_top,
    input  logic [ADDR_W-1:0] br,
    input  logic [ADDR_W-1:0] disp,
    output logic [ADDR_W-1:0] nxt,
    output logic [ADDR_W-1:0] inc,
    output logic              push,
    output logic              pop
);

    logic take;

    always_comb begin
        inc  = cur + ADDR_W'(1);
        take = ~ctl.cond_en | hit;
        nxt  = inc;
        push = 1'b0;
        pop  = 1'b0;
        if (take) begin
            unique case (ctl.src)
                SRC_INC: begin
                    nxt = inc;
                end
                SRC_STACK: begin
                    nxt = stk_top;
                    pop = 1'b1;
                end
                SRC_BRANCH: begin
                    nxt  = br;
                    push = ctl.push;
                end
                SRC_DISPATCH: begin
                    nxt  = disp;
                    push = ctl.push;
                end
                default: nxt = inc;
            endcase
        end
    end

endmodule

// File: rtl/mseq_ret_stack.sv
module mseq_ret_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] top
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0]          ptr;
        logic [DEPTH-1:0][W-1:0]   ent;
    } stk_t;

    stk_t st_d, st_q;
    logic [PTR_W-1:0] below;
    logic [PTR_W-1:0] above;

    function automatic logic [PTR_W-1:0] ptr_up(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dn(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST : p - PTR_W'(1);
    endfunction

    assign below = ptr_dn(st_q.ptr);
    assign above = ptr_up(st_q.ptr);
    assign top   = st_q.ent[below];

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            if (push) begin
                st_d.ent[st_q.ptr] = wdata;
                st_d.ptr           = above;
            end else if (pop) begin
                st_d.ptr = below;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/mseq_core.sv
module mseq_core
    import mseq_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int STK_DEPTH = 4,
    parameter int CSEL_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        ctl_word,
    input  logic [CSEL_W-1:0] cond_sel,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_n,
    input  logic              ext_cond,
    input  logic [ADDR_W-1:0] branch_tgt,
    input  logic [ADDR_W-1:0] dispatch_in,
    input  logic              stall,
    output logic [ADDR_W-1:0] uaddr
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t              seq_d, seq_q;
    ctl_t              ctl;
    logic              hit;
    logic              do_push, do_pop;
    logic [ADDR_W-1:0] nxt, inc, stk_top;

    assign ctl = ctl_t'(ctl_word[CTL_W-1:0]);

    mseq_cond_mux #(.SEL_W(CSEL_W)) u_cond (
        .sel (cond_sel),
        .z   (flag_z),
        .c   (flag_c),
        .n   (flag_n),
        .ext (ext_cond),
        .hit (hit)
    );

    mseq_next_sel #(.ADDR_W(ADDR_W)) u_next (
        .cur     (seq_q.addr),
        .ctl     (ctl),
        .hit     (hit),
        .stk_top (stk_top),
        .br      (branch_tgt),
        .disp    (dispatch_in),
        .nxt     (nxt),
        .inc     (inc),
        .push    (do_push),
        .pop     (do_pop)
    );

    mseq_ret_stack #(.DEPTH(STK_DEPTH), .W(ADDR_W)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .hold  (stall),
        .push  (do_push),
        .pop   (do_pop),
        .wdata (inc),
        .top   (stk_top)
    );

    always_comb begin
        seq_d = seq_q;
        if (!stall) seq_d.addr = nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign uaddr = seq_q.addr;

endmodule

// File: rtl/mseq_chk.sv
module mseq_chk
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CSEL_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        ctl_word,
    input logic [CSEL_W-1:0] cond_sel,
    input logic [ADDR_W-1:0] branch_tgt,
    input logic [ADDR_W-1:0] dispatch_in,
    input logic              stall,
    input logic [ADDR_W-1:0] uaddr
);

    ctl_t              c;
    logic [ADDR_W-1:0] plus1;
    logic              rst_seen_q;

    assign c     = ctl_t'(ctl_word[CTL_W-1:0]);
    assign plus1 = uaddr + ADDR_W'(1);

    always_ff @(posedge clk) rst_seen_q <= rst;

    // R9
    always_ff @(posedge clk) begin
        if (rst_seen_q == 1'b1) begin
            reset_zero_chk: assert (uaddr == '0) else $error("address not zero after reset");
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(uaddr));

    // R1
    seq_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && c.src == SRC_INC) |=> uaddr == $past(plus1));

    // R3
    branch_uncond_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !c.cond_en && c.src == SRC_BRANCH) |=> uaddr == $past(branch_tgt));

    // R4
    dispatch_uncond_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !c.cond_en && c.src == SRC_DISPATCH) |=> uaddr == $past(dispatch_in));

    // R5
    cond_always_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && c.cond_en && cond_sel == CSEL_W'(0) && c.src == SRC_BRANCH)
        |=> uaddr == $past(branch_tgt));

    // R6
    cond_never_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && c.cond_en && cond_sel == CSEL_W'(7)) |=> uaddr == $past(plus1));

endmodule

bind mseq_core mseq_chk #(.ADDR_W(ADDR_W), .CSEL_W(CSEL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_word    (ctl_word),
    .cond_sel    (cond_sel),
    .branch_tgt  (branch_tgt),
    .dispatch_in (dispatch_in),
    .stall       (stall),
    .uaddr       (uaddr)
);

// File: tb/mseq_core_tb.sv
`timescale 1ns/1ps
module mseq_core_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] ctl_word;
    logic [2:0] cond_sel;
    logic       flag_z, flag_c, flag_n, ext_cond;
    logic [8:0] branch_tgt, dispatch_in;
    logic       stall;
    logic [8:0] uaddr;

    always #4 clk = ~clk;

    mseq_core u_dut (
        .clk(clk), .rst(rst), .ctl_word(ctl_word), .cond_sel(cond_sel),
        .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .ext_cond(ext_cond),
        .branch_tgt(branch_tgt), .dispatch_in(dispatch_in), .stall(stall),
        .uaddr(uaddr)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference
    int    m_addr;
    int    m_stk[4];
    int    m_sp;
    string m_tag;

    function automatic bit test_bit(input int cs);
        case (cs)
            0: return 1'b1;
            1: return flag_z;
            2: return !flag_z;
            3: return flag_c;
            4: return !flag_c;
            5: return flag_n;
            6: return ext_cond;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        int  nx;
        int  src;
        bit  take;
        if (rst) begin
            m_addr = 0; m_sp = 0;
            foreach (m_stk[i]) m_stk[i] = 0;
            m_tag = "R9";
        end else if (stall) begin
            m_tag = "R8";
        end else begin
            nx   = (m_addr + 1) % 512;
            src  = int'(ctl_word[1:0]);
            take = !ctl_word[2] || test_bit(int'(cond_sel));
            if (src == 0) begin
                m_addr = nx; m_tag = "R1";
            end else if (!take) begin
                m_addr = nx; m_tag = "R6";
            end else if (src == 1) begin
                m_sp   = (m_sp + 3) % 4;
                m_addr = m_stk[m_sp];
                m_tag  = "R2";
            end else begin
                m_addr = (src == 2) ? int'(branch_tgt) : int'(dispatch_in);
                m_tag  = ctl_word[2] ? "R5" : ((src == 2) ? "R3" : "R4");
                if (ctl_word[3]) begin
                    m_stk[m_sp] = nx;
                    m_sp = (m_sp + 1) % 4;
                    m_tag = "R7";
                end
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // drive at negedge, compare at the following negedge
    task automatic cyc(input bit r, input bit st, input logic [3:0] cw,
                       input logic [2:0] cs, input logic [3:0] flg,
                       input logic [8:0] br, input logic [8:0] dp);
        rst = r; stall = st; ctl_word = cw; cond_sel = cs;
        {flag_z, flag_c, flag_n, ext_cond} = flg;
        branch_tgt = br; dispatch_in = dp;
        @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (uaddr !== 9'(m_addr)) begin
            n_bad++;
            $display("FAIL %s: uaddr=%0d expected %0d", m_tag, uaddr, m_addr);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, got 0 expected completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        // R9: reset state
        repeat (3) cyc(1, 0, 4'h0, 3'd0, 4'h0, 9'd0, 9'd0);
        // R1: sequential flow and wrap at the top of the address space
        repeat (4) cyc(0, 0, 4'h0, 3'd0, 4'h0, 9'd0, 9'd0);
        cyc(0, 0, 4'b0010, 3'd0, 4'h0, 9'd510, 9'd0);  // R3
        repeat (3) cyc(0, 0, 4'h0, 3'd0, 4'h0, 9'd0, 9'd0);
        // R4: dispatch
        cyc(0, 0, 4'b0011, 3'd0, 4'h0, 9'd0, 9'd77);
        // R5 / R6: every condition against every flag pattern
        for (int cs = 0; cs < 8; cs++)
            for (int f = 0; f < 16; f++)
                cyc(0, 0, 4'b0110, 3'(cs), 4'(f), 9'(40 + cs * 16 + f), 9'd0);
        // R7: five nested calls wrap the stack, then six returns (R2)
        for (int k = 0; k < 5; k++) begin
            cyc(0, 0, 4'b1010, 3'd0, 4'h0, 9'(100 * k + 3), 9'd0);
            cyc(0, 1, 4'b0001, 3'd0, 4'h0, 9'd0, 9'd0);   // R8: stalled return
        end
        for (int k = 0; k < 6; k++) begin
            cyc(0, 0, 4'b0001, 3'd0, 4'h0, 9'd0, 9'd0);
            cyc(0, 0, 4'h0, 3'd0, 4'h0, 9'd0, 9'd0);
        end
        // R6: failing conditional call does not push
        cyc(0, 0, 4'b1111, 3'd7, 4'hF, 9'd0, 9'd300);
        cyc(0, 0, 4'b1011, 3'd0, 4'h0, 9'd0, 9'd200);
        cyc(0, 0, 4'b0001, 3'd0, 4'h0, 9'd0, 9'd0);
        // R9: reset wins over stall mid-run
        cyc(0, 0, 4'b1010, 3'd0, 4'h0, 9'd123, 9'd0);
        cyc(1, 1, 4'h0, 3'd0, 4'h0, 9'd0, 9'd0);
        cyc(0, 0, 4'b0001, 3'd0, 4'h0, 9'd0, 9'd0);
        // randomized mix
        for (int k = 0; k < 4000; k++) begin
            cyc(($urandom_range(0, 99) == 0), ($urandom_range(0, 9) == 0),
                4'($urandom), 3'($urandom), 4'($urandom),
                9'($urandom), 9'($urandom));
        end
        summary();
        $finish;
    end

endmodule